// File: doc/BRIEF.md
# Battery Capacity Learning Controller

This block watches one learning discharge of a battery and derives a fresh value for its learned full capacity. The learning cycle arms at the full condition, which is when the remaining capacity reported by the fuel-gauge datapath equals the learned capacity. While armed, it counts discharge-charge increment strobes, one capacity unit per strobe. The cycle ends when a qualifier upstream reports that the measured voltage has fallen to or below the first end-of-discharge threshold. At that point the block publishes a new learned capacity. That value is the counted charge plus an allowance of one sixteenth of the old capacity for the charge still left below the threshold. It may not drop by more than one eighth of the old capacity in a single cycle.

A disqualifying event abandons the cycle and leaves the learned value untouched. Separately, the block counts charge cycles since the last completed learning cycle and raises a capacity-inaccurate flag when that count grows stale. Coulomb counting, voltage measurement and threshold filtering sit outside the block.

Top module: `cap_learn_ctrl`

## Requirements
- R1: After reset, the valid-discharge flag is 0, the capacity-inaccurate flag is 1, the cycle counter is 0 and the learned-capacity output is 0.
- R2: With the valid-discharge flag clear and disqualify low, a cycle where remaining capacity equals learned capacity sets the flag on the next clock. The learned capacity of that cycle becomes the old value for the learning cycle, and the charge tally restarts from zero.
- R3: Once set, the valid-discharge flag stays set while neither disqualify nor the end-of-discharge detect is high, whatever the capacity inputs do.
- R4: Disqualify while armed clears the valid-discharge flag on the next clock and leaves the learned-capacity output unchanged, even if end-of-discharge is high in the same cycle.
- R5: End-of-discharge while armed and not disqualified completes the cycle. It clears the valid-discharge flag, and on the next clock the output becomes T + (old >> 4). T is the number of increment strobes seen in the cycles strictly after the arming cycle and strictly before the completing cycle.
- R6: The value published at completion is never below old - (old >> 3); a smaller result is raised to that floor.
- R7: If T + (old >> 4) exceeds 65535, the published value is 65535.
- R8: A completed learning cycle clears the capacity-inaccurate flag and the cycle counter to 0 on the next clock, and a cycle-completed strobe in that same cycle is ignored.
- R9: Each cycle-completed strobe outside a completing cycle adds 1 to the cycle counter, which holds at 255.
- R10: The capacity-inaccurate flag is set on the clock where the cycle counter reaches 32 or more, and stays set until the next completed learning cycle.
- R11: End-of-discharge with the valid-discharge flag clear changes nothing on the outputs.
- R12: The charge tally saturates at 65535, so further strobes do not wrap it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| rem_cap_i | input | 16 | Remaining capacity from the gauge datapath |
| lrn_cap_i | input | 16 | Currently learned full capacity |
| dchg_tick_i | input | 1 | One unit of discharged charge |
| disq_i | input | 1 | Disqualifying event |
| eod_hit_i | input | 1 | Voltage at or below the first end-of-discharge threshold, from the qualifier |
| cyc_done_i | input | 1 | A charge cycle has completed |
| new_cap_o | output | 16 | Most recently learned full capacity |
| vld_dchg_o | output | 1 | Learning discharge in progress |
| cap_inacc_o | output | 1 | Learned capacity considered inaccurate |
| cyc_since_o | output | 8 | Charge cycles since the last learning cycle |

## Verification
The bench goes after the arithmetic edges. A small tally against a large old capacity must be caught by the one-eighth floor; a design that skipped the floor would publish a collapsed capacity. Long runs of strobes must saturate both the tally and the sum; a wrapping adder would turn a huge capacity into a tiny one. It also covers the priority of disqualify over end-of-discharge, which a careless design would resolve as a learning update. It checks the exact 31st and 32nd cycle strobes, where an off-by-one threshold moves the inaccurate flag by a cycle, and a completion that coincides with a cycle strobe, which must leave the counter at zero.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_ARMED = 1'b1
  } lrn_phase_e;
endpackage

// File: rtl/cl_accum.sv
module cl_accum #(
  parameter int unsigned CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CAP_W-1:0] tally_o
);
  localparam logic [CAP_W-1:0] TALLY_MAX = {CAP_W{1'b1}};

  logic [CAP_W-1:0] tally_q, tally_d;
  logic             tally_en;

  always_comb begin
    tally_en = clr_i || (tick_i && (tally_q != TALLY_MAX));
    tally_d  = clr_i ? '0 : tally_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tally_q <= '0;
    else if (tally_en) tally_q <= tally_d;
  end

  assign tally_o = tally_q;

  p_tally_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tally_q == TALLY_MAX && tick_i && !clr_i) |=> (tally_q == TALLY_MAX));
endmodule

// File: rtl/cl_calc.sv
module cl_calc #(
  parameter int unsigned CAP_W    = 16,
  parameter int unsigned ALLOW_SH = 4,
  parameter int unsigned LIMIT_SH = 3
) (
  input  logic [CAP_W-1:0] tally_i,
  input  logic [CAP_W-1:0] old_cap_i,
  output logic [CAP_W-1:0] result_o
);
  localparam logic [CAP_W-1:0] CAP_MAX = {CAP_W{1'b1}};

  logic [CAP_W:0]   sum_w;
  logic [CAP_W-1:0] sum_sat;
  logic [CAP_W-1:0] floor_v;

  always_comb begin
    sum_w    = {1'b0, tally_i} + {1'b0, (old_cap_i >> ALLOW_SH)};
    sum_sat  = sum_w[CAP_W] ? CAP_MAX : sum_w[CAP_W-1:0];
    floor_v  = old_cap_i - (old_cap_i >> LIMIT_SH);
    result_o = (sum_sat < floor_v) ? floor_v : sum_sat;
  end

  always_comb begin
    a_floor_r6: assert (result_o >= old_cap_i - (old_cap_i >> LIMIT_SH));
  end
endmodule

// File: rtl/cl_cyc_ctr.sv
module cl_cyc_ctr #(
  parameter int unsigned CYC_W     = 8,
  parameter int unsigned INACC_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CYC_W-1:0] cnt_o,
  output logic             inacc_o
);
  localparam logic [CYC_W-1:0] CNT_MAX   = {CYC_W{1'b1}};
  localparam logic [CYC_W-1:0] CNT_STALE = CYC_W'(INACC_CYC);

  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             inacc_q, inacc_d;
  logic             upd_en;

  always_comb begin
    upd_en  = clr_i || inc_i;
    cnt_d   = cnt_q;
    inacc_d = inacc_q;
    if (clr_i) begin
      cnt_d   = '0;
      inacc_d = 1'b0;
    end else if (inc_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (cnt_d >= CNT_STALE) inacc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      inacc_q <= 1'b1;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      inacc_q <= inacc_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign inacc_o = inacc_q;

  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc_i && !clr_i) |=> (cnt_q == CNT_MAX));
  p_stale_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CNT_STALE) |-> inacc_q);
endmodule

// File: rtl/cap_learn_ctrl.sv
module cap_learn_ctrl #(
  parameter int unsigned CAP_W     = 16,
  parameter int unsigned CYC_W     = 8,
  parameter int unsigned INACC_CYC = 32,
  parameter int unsigned ALLOW_SH  = 4,
  parameter int unsigned LIMIT_SH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] rem_cap_i,
  input  logic [CAP_W-1:0] lrn_cap_i,
  input  logic             dchg_tick_i,
  input  logic             disq_i,
  input  logic             eod_hit_i,
  input  logic             cyc_done_i,
  output logic [CAP_W-1:0] new_cap_o,
  output logic             vld_dchg_o,
  output logic             cap_inacc_o,
  output logic [CYC_W-1:0] cyc_since_o
);
  import cl_pkg::*;

  lrn_phase_e       phase_q, phase_d;
  logic [CAP_W-1:0] base_q;
  logic [CAP_W-1:0] cap_q;
  logic [CAP_W-1:0] tally_w;
  logic [CAP_W-1:0] result_w;
  logic             armed, arm_ev, done_ev, drop_ev;

  always_comb begin
    armed   = (phase_q == PH_ARMED);
    arm_ev  = !armed && (rem_cap_i == lrn_cap_i) && !disq_i;
    drop_ev = armed && disq_i;
    done_ev = armed && eod_hit_i && !disq_i;
    phase_d = phase_q;
    if (arm_ev)                  phase_d = PH_ARMED;
    else if (drop_ev || done_ev) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (arm_ev) base_q <= lrn_cap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (done_ev) cap_q <= result_w;
  end

  cl_accum #(.CAP_W(CAP_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (arm_ev),
    .tick_i  (armed && dchg_tick_i),
    .tally_o (tally_w)
  );

  cl_calc #(.CAP_W(CAP_W), .ALLOW_SH(ALLOW_SH), .LIMIT_SH(LIMIT_SH)) u_calc (
    .tally_i   (tally_w),
    .old_cap_i (base_q),
    .result_o  (result_w)
  );

  cl_cyc_ctr #(.CYC_W(CYC_W), .INACC_CYC(INACC_CYC)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (done_ev),
    .inc_i   (cyc_done_i),
    .cnt_o   (cyc_since_o),
    .inacc_o (cap_inacc_o)
  );

  assign new_cap_o  = cap_q;
  assign vld_dchg_o = armed;

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_dchg_o && rem_cap_i == lrn_cap_i && !disq_i) |=> vld_dchg_o);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_dchg_o && !disq_i && !eod_hit_i) |=> vld_dchg_o);
  p_disq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_dchg_o && disq_i) |=> (!vld_dchg_o && $stable(new_cap_o)));
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_dchg_o && eod_hit_i && !disq_i) |=> (!cap_inacc_o && cyc_since_o == '0 && !vld_dchg_o));
  p_idle_eod_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_dchg_o && eod_hit_i) |=> $stable(new_cap_o));
endmodule

// File: tb/cap_learn_ctrl_tb_top.sv
module cap_learn_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] rem_cap, lrn_cap;
  logic        tick, disq, eod, cdone;
  logic [15:0] new_cap;
  logic        vld, inacc;
  logic [7:0]  cyc;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned n_cyc = 0;
  bit          done_flag = 1'b0;

  logic [15:0] m_new, m_acc, m_base;
  logic        m_vld, m_ci;
  logic [7:0]  m_cyc;

  always #10 clk = ~clk;

  cap_learn_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .rem_cap_i(rem_cap), .lrn_cap_i(lrn_cap),
    .dchg_tick_i(tick), .disq_i(disq), .eod_hit_i(eod), .cyc_done_i(cdone),
    .new_cap_o(new_cap), .vld_dchg_o(vld), .cap_inacc_o(inacc), .cyc_since_o(cyc)
  );

  function automatic logic [15:0] exp_cap(input logic [15:0] t, input logic [15:0] old);
    int s, f;
    s = int'(t) + int'(old >> 4);
    if (s > 65535) s = 65535;
    f = int'(old) - int'(old >> 3);
    if (s < f) s = f;
    return 16'(s);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 vld", vld, m_vld);
    chk("R10 inacc", inacc, m_ci);
    chk("R9 cyc", cyc, m_cyc);
    chk("R5 newcap", new_cap, m_new);
  endtask

  task automatic tick1(input logic [15:0] rc, input logic [15:0] lc,
                       input logic tk, input logic dq, input logic ed, input logic cd,
                       input bit cmp);
    logic arm, fin;
    @(negedge clk);
    rem_cap = rc; lrn_cap = lc; tick = tk; disq = dq; eod = ed; cdone = cd;
    arm = !m_vld && rc == lc && !dq;
    fin = m_vld && ed && !dq;
    if (arm) begin
      m_vld = 1'b1; m_acc = '0; m_base = lc;
    end else if (m_vld && dq) begin
      m_vld = 1'b0;
    end else if (fin) begin
      m_vld = 1'b0; m_new = exp_cap(m_acc, m_base); m_cyc = '0; m_ci = 1'b0;
    end else if (m_vld && tk && m_acc != 16'hFFFF) begin
      m_acc = m_acc + 1'b1;
    end
    if (!fin && cd) begin
      if (m_cyc != 8'hFF) m_cyc = m_cyc + 1'b1;
      if (m_cyc >= 8'd32) m_ci = 1'b1;
    end
    @(posedge clk);
    #2;
    if (cmp) cmp_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick1(16'd1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic learn(input logic [15:0] base, input int strobes);
    tick1(base, base, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < strobes; i++)
      tick1(16'd1, base, 1'b1, 1'b0, 1'b0, 1'b0, (i % 256) == 0);
    tick1(16'd1, base, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 195000 && !done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", n_cyc, 195000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; rem_cap = 16'd1; lrn_cap = 16'd2;
    tick = 0; disq = 0; eod = 0; cdone = 0;
    m_new = '0; m_acc = '0; m_base = '0; m_vld = 0; m_ci = 1; m_cyc = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 vld", vld, 0); chk("R1 inacc", inacc, 1);
    chk("R1 cyc", cyc, 0); chk("R1 newcap", new_cap, 0);
    @(negedge clk); rst_n = 1'b1;

    // R11: end-of-discharge while idle
    tick1(16'd5, 16'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R11 newcap", new_cap, 0); chk("R11 vld", vld, 0);

    // R2/R3/R5: plain learning, 200 strobes on base 160 -> 210
    tick1(16'd160, 16'd160, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2 armed", vld, 1);
    for (int i = 0; i < 200; i++)
      tick1(16'd160, 16'(i), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 held", vld, 1);
    tick1(16'd3, 16'd160, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R5 newcap", new_cap, 210);
    chk("R8 inacc", inacc, 0); chk("R8 cyc", cyc, 0); chk("R5 vld", vld, 0);

    // R10: 31 strobes keep flag clear, 32nd sets it
    for (int i = 0; i < 31; i++) tick1(16'd1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 at31", inacc, 0);
    tick1(16'd1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 at32", inacc, 1); chk("R10 cyc", cyc, 32);

    // R9: saturation at 255
    for (int i = 0; i < 260; i++) tick1(16'd1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 sat", cyc, 255);

    // R4: disqualify together with end-of-discharge
    tick1(16'd500, 16'd500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) tick1(16'd1, 16'd500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    tick1(16'd1, 16'd500, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R4 vld", vld, 0); chk("R4 newcap", new_cap, 210); chk("R4 inacc", inacc, 1);

    // R6: floor, base 1600 with 100 strobes -> 1400
    learn(16'd1600, 100);
    chk("R6 floor", new_cap, 1400);

    // R12: tally saturation, base 0
    learn(16'd0, 65600);
    chk("R12 tally", new_cap, 65535);

    // R7: sum saturation, base 65520 with 65530 strobes
    learn(16'd65520, 65530);
    chk("R7 sum", new_cap, 65535);

    // R3 and mixed: random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] lc, rc;
      lc = 16'(($urandom % 8) * 300);
      rc = (($urandom % 4) == 0) ? lc : 16'($urandom % 2400);
      tick1(rc, lc, ($urandom % 2) == 0, ($urandom % 90) == 0,
            ($urandom % 60) == 0, ($urandom % 8) == 0, 1'b1);
    end
    idle(4);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule